// File: doc/BRIEF.md
# Paged Serial Register Slave

This block is a serial slave that exposes a bank of 24-bit registers to an external controller over a four-wire link: a clock, an active-low select, a data input and a data output. Each transfer opens with a one-byte command, sent most significant bit first, that carries a write/read flag and a 5-bit register address. A read then returns the addressed 24-bit word on the data output. A write collects a 24-bit word and stores it only once the whole word has arrived.

The register space is split into pages of 32 addresses. A write to address 31 picks the active page instead of storing data. A read of address 31 returns that page's own read-only word. The bank here is a small behavioural model for test. Page 0 fills addresses 0 to 30. Every higher page fills only its lower addresses. Address 31 on each page holds a fixed read-only pattern.

The serial pins are brought into the system clock domain through two-flop synchronisers and then edge-detected. The serial clock must therefore run well below the system clock.

Top module: `sr_paged_slave`

## Requirements
- R1: After reset the active page is 0, the data output is 0, and every implemented register holds 0x5A0000 + 256*page + address.
- R2: The command byte is taken on rising serial-clock edges, most significant bit first. Bit 6 is the write/read flag (1 = write, 0 = read), bits 5..1 are the register address, and bits 7 and 0 are ignored.
- R3: After a read command, the 24-bit word is presented most significant bit first. Each bit changes only on a falling serial-clock edge. The first bit is valid after the falling edge that follows the eighth rising edge.
- R4: A write stores its 24-bit word only after the 24th data bit. If the select is released before that bit, the target register is left unchanged.
- R5: A write to address 31 sets the active page when the written value is below PAGES. Any other value is ignored and the page is kept.
- R6: A read of address 31 returns the current page's read-only word (0x5A0000 + 256*page + 31), never the page number.
- R7: On pages above 0, addresses at or above HI_PAGE_REGS (16 by default) are unimplemented. Writes to them are ignored, and reads of them return 0.
- R8: Releasing the select at any point, including inside the command byte, abandons the transfer. The next transfer starts with a fresh command byte.
- R9: Data bits sent after the 24th bit of a write are ignored.
- R10: The data output is 0 while the select is released, during the command byte, and throughout a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial clock from the controller |
| ser_cs_n | input | 1 | Active-low transfer select |
| ser_din | input | 1 | Serial data into the slave |
| ser_dout | output | 1 | Serial data out of the slave |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. Each serial-clock level and each select change must last several system cycles, so that edge pulses are single-cycle and a commit never coincides with a falling-edge update. The bench holds each serial-clock half period for eight system cycles. It changes the data input only while the serial clock is low, and it keeps the select high for eight cycles between transfers. The sweeps cover every address on both pages, out-of-range page values, transfers abandoned inside the command byte and inside the data word, and writes padded with surplus bits.

// File: rtl/sr_paged_pkg.sv
package sr_paged_pkg;
  localparam int CMD_BITS  = 8;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 24;
  localparam int PAGE_REGS = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] RST_TAG = 24'h5A0000;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  function automatic logic [DATA_W-1:0] rst_word(input int pg, input int ad);
    rst_word = RST_TAG + DATA_W'(pg * 256) + DATA_W'(ad);
  endfunction
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stg [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q      = stg[STAGES-1];
  assign q_prev = stg[STAGES];
endmodule

// File: rtl/sr_frame_ctrl.sv
module sr_frame_ctrl
  import sr_paged_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_idle,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout
);
  localparam int CNT_W = $clog2(DATA_W);

  phase_e            phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [DATA_W-1:0] out_q, out_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              dout_q, dout_n;
  logic              last_cmd, last_data;

  assign last_cmd  = (cnt_q == CNT_W'(CMD_BITS - 1));
  assign last_data = (cnt_q == CNT_W'(DATA_W - 1));
  assign rd_addr   = sh_q[ADDR_W-1:0];
  assign wr_addr   = addr_q;
  assign wr_data   = {sh_q[DATA_W-2:0], din};
  assign wr_en     = !cs_idle && rise && (phase_q == PH_WR) && last_data;
  assign dout      = dout_q;

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    out_n   = out_q;
    addr_n  = addr_q;
    dout_n  = dout_q;
    if (cs_idle) begin
      phase_n = PH_CMD;
      cnt_n   = '0;
      dout_n  = 1'b0;
    end else if (rise) begin
      sh_n = {sh_q[DATA_W-2:0], din};
      unique case (phase_q)
        PH_CMD: begin
          if (last_cmd) begin
            cnt_n  = '0;
            addr_n = sh_q[ADDR_W-1:0];
            if (sh_q[ADDR_W]) begin
              phase_n = PH_WR;
            end else begin
              phase_n = PH_RD;
              out_n   = rd_data;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        PH_WR: begin
          if (last_data) phase_n = PH_DONE;
          else           cnt_n   = cnt_q + 1'b1;
        end
        default: ;
      endcase
    end else if (fall && phase_q == PH_RD) begin
      dout_n = out_q[DATA_W-1];
      out_n  = {out_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      out_q   <= '0;
      addr_q  <= '0;
      dout_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      out_q   <= out_n;
      addr_q  <= addr_n;
      dout_q  <= dout_n;
    end
  end
endmodule

// File: rtl/sr_reg_bank.sv
module sr_reg_bank
  import sr_paged_pkg::*;
#(
  parameter int PAGES        = 2,
  parameter int HI_PAGE_REGS = 16,
  localparam int PAGE_W      = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [PAGE_W-1:0] page
);
  localparam int CELLS = PAGES * PAGE_REGS;
  localparam logic [ADDR_W-1:0] SEL_ADDR = '1;

  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] cell_rd [CELLS];
  logic              page_wr;

  assign page_wr = wr_en && (wr_addr == SEL_ADDR) && (wr_data < DATA_W'(PAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_wr) page_q <= wr_data[PAGE_W-1:0];
  end

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    for (genvar a = 0; a < PAGE_REGS; a++) begin : g_reg
      if (a == PAGE_REGS - 1) begin : g_fixed
        assign cell_rd[p*PAGE_REGS+a] = rst_word(p, a);
      end else if (p == 0 || a < HI_PAGE_REGS) begin : g_store
        logic [DATA_W-1:0] q;
        logic              we;
        assign we = wr_en && (wr_addr == ADDR_W'(a)) && (page_q == PAGE_W'(p));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  q <= rst_word(p, a);
          else if (we) q <= wr_data;
        end
        assign cell_rd[p*PAGE_REGS+a] = q;
      end else begin : g_hole
        assign cell_rd[p*PAGE_REGS+a] = '0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < CELLS; i++) begin
      if (i == int'(page_q) * PAGE_REGS + int'(rd_addr)) rd_data = cell_rd[i];
    end
  end

  assign page = page_q;
endmodule

// File: rtl/sr_paged_slave.sv
module sr_paged_slave
  import sr_paged_pkg::*;
#(
  parameter int PAGES        = 2,
  parameter int HI_PAGE_REGS = 16,
  parameter int SYNC_STAGES  = 2,
  localparam int PAGE_W      = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_cs_n,
  input  logic ser_din,
  output logic ser_dout
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [2:0] pins_s, pins_p;
  logic       sclk_rise, sclk_fall, cs_idle, din_s;

  sr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .d      ({ser_din, ser_cs_n, ser_clk}),
    .q      (pins_s),
    .q_prev (pins_p)
  );

  assign sclk_rise = pins_s[0] && !pins_p[0];
  assign sclk_fall = !pins_s[0] && pins_p[0];
  assign cs_idle   = pins_s[1];
  assign din_s     = pins_s[2];

  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;
  logic [PAGE_W-1:0] page;

  sr_frame_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cs_idle (cs_idle),
    .rise    (sclk_rise),
    .fall    (sclk_fall),
    .din     (din_s),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .dout    (ser_dout)
  );

  sr_reg_bank #(.PAGES(PAGES), .HI_PAGE_REGS(HI_PAGE_REGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .page    (page)
  );
endmodule

// File: rtl/sr_paged_slave_chk.sv
module sr_paged_slave_chk #(
  parameter int PAGES  = 2,
  parameter int PAGE_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_dout,
  input logic             cs_idle,
  input logic             sclk_fall,
  input logic             wr_en,
  input logic [4:0]       wr_addr,
  input logic [PAGE_W-1:0] page
);
  // R5: the active page never leaves the legal range
  p_page_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(page) < PAGES);

  // R5: the page moves only on a committed write to address 31
  p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 5'd31) |=> $stable(page));

  // R4: a commit is a single-cycle event
  p_commit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R8: nothing is committed while the select is released
  p_commit_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cs_idle);

  // R10: output is low once the select is released
  p_dout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !ser_dout);

  // R3: output changes only after a falling serial-clock edge
  p_dout_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_idle) |=> $stable(ser_dout));
endmodule

bind sr_paged_slave sr_paged_slave_chk #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ser_dout  (ser_dout),
  .cs_idle   (cs_idle),
  .sclk_fall (sclk_fall),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .page      (page)
);

// File: tb/sr_paged_slave_test.sv
module sr_paged_slave_test;
  localparam int HALF = 8;

  logic clk, rst_n, sclk, cs_n, din;
  wire  dout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sr_paged_slave uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (sclk),
    .ser_cs_n (cs_n),
    .ser_din  (din),
    .ser_dout (dout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [23:0] rstv(input int p, input int a);
    rstv = 24'h5A0000 + 24'(p * 256) + 24'(a);
  endfunction

  function automatic logic [23:0] pat(input int a, input int salt);
    pat = 24'(a * 24'h010203) ^ 24'(salt * 24'h0F1E2D) ^ 24'hC35A96;
  endfunction

  task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic got);
    @(negedge clk) din = b;
    repeat (HALF) @(negedge clk);
    got  = dout;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic open_frame();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_frame();
    @(negedge clk) begin cs_n = 1'b1; sclk = 1'b0; din = 1'b0; end
    repeat (8) @(negedge clk);
  endtask

  // sends nbits of the command byte; returns OR of sampled output
  task automatic send_cmd(input logic wr, input logic [4:0] a, input int nbits,
                          input logic b7, output logic seen);
    logic [7:0] cb;
    logic g;
    cb   = {b7, wr, a, b7};
    seen = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) begin
      xbit(cb[i], g);
      seen |= g;
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d, input int nbits,
                          output logic seen);
    logic g, s;
    open_frame();
    send_cmd(1'b1, a, 8, 1'b0, s);
    seen = s;
    for (int i = 31; i > 31 - nbits; i--) begin
      xbit(d[i], g);
      seen |= g;
    end
    close_frame();
  endtask

  task automatic do_read(input logic [4:0] a, input logic b7, output logic [23:0] d,
                         output logic seen);
    logic g;
    open_frame();
    send_cmd(1'b0, a, 8, b7, seen);
    for (int i = 23; i >= 0; i--) begin
      xbit(1'b1, g);
      d[i] = g;
    end
    close_frame();
  endtask

  task automatic wr24(input logic [4:0] a, input logic [23:0] d);
    logic s;
    do_write(a, {d, 8'h00}, 24, s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] rd;
    logic        s;
    logic [23:0] shadow1 [16];
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset state
    chk({23'd0, dout}, 24'd0, "R1 dout after reset");
    for (int a = 0; a < 32; a++) begin
      do_read(5'(a), 1'b0, rd, s);
      chk(rd, rstv(0, a), (a == 31) ? "R6 page0 addr31 read" : "R1 page0 reset word");
      chk({23'd0, s}, 24'd0, "R10 dout low in command byte");
    end

    // R2/R3/R4: write every page-0 address, then read back
    for (int a = 0; a < 31; a++) begin
      do_write(5'(a), {pat(a, 0), 8'h00}, 24, s);
      chk({23'd0, s}, 24'd0, "R10 dout low during write");
    end
    for (int a = 0; a < 31; a++) begin
      do_read(5'(a), a[0], rd, s);
      chk(rd, pat(a, 0), "R2 R3 R4 page0 write/read back, bits 7/0 ignored");
    end
    chk({23'd0, dout}, 24'd0, "R10 dout low while deselected");

    // R5: move to page 1
    wr24(5'd31, 24'd1);
    do_read(5'd31, 1'b0, rd, s);
    chk(rd, rstv(1, 31), "R6 page1 addr31 read is fixed word");
    for (int a = 0; a < 31; a++) begin
      do_read(5'(a), 1'b0, rd, s);
      chk(rd, (a < 16) ? rstv(1, a) : 24'd0, "R1 R7 page1 reset map");
    end

    // R7: writes to holes ignored, implemented page-1 cells written
    for (int a = 0; a < 31; a++) wr24(5'(a), pat(a, 1));
    for (int a = 0; a < 31; a++) begin
      do_read(5'(a), 1'b0, rd, s);
      chk(rd, (a < 16) ? pat(a, 1) : 24'd0, "R7 page1 write map");
      if (a < 16) shadow1[a] = pat(a, 1);
    end

    // R5: out-of-range page values ignored
    wr24(5'd31, 24'd2);
    do_read(5'd3, 1'b0, rd, s);
    chk(rd, shadow1[3], "R5 page value 2 ignored");
    wr24(5'd31, 24'hFFFFFF);
    do_read(5'd20, 1'b0, rd, s);
    chk(rd, 24'd0, "R5 page value FFFFFF ignored");

    // back to page 0
    wr24(5'd31, 24'd0);
    do_read(5'd3, 1'b0, rd, s);
    chk(rd, pat(3, 0), "R5 return to page 0");
    do_read(5'd31, 1'b0, rd, s);
    chk(rd, rstv(0, 31), "R6 addr31 read after page write");

    // R4: partial words abandoned at several lengths
    for (int n = 1; n < 24; n += 5) begin
      do_write(5'd4, 32'hFFFFFFFF, n, s);
      do_read(5'd4, 1'b0, rd, s);
      chk(rd, pat(4, 0), "R4 partial write leaves register");
    end

    // R8: abort inside the command byte, then full transfers
    for (int n = 1; n < 8; n += 2) begin
      open_frame();
      send_cmd(1'b1, 5'd5, n, 1'b0, s);
      close_frame();
      do_read(5'd6, 1'b0, rd, s);
      chk(rd, pat(6, 0), "R8 fresh command after abort");
    end
    do_read(5'd5, 1'b0, rd, s);
    chk(rd, pat(5, 0), "R8 aborted command wrote nothing");

    // R9: surplus write bits ignored
    do_write(5'd7, {24'h13579B, 8'hFF}, 32, s);
    do_read(5'd7, 1'b0, rd, s);
    chk(rd, 24'h13579B, "R9 surplus bits ignored");
    do_write(5'd8, {24'hECA864, 8'hA5}, 29, s);
    do_read(5'd8, 1'b0, rd, s);
    chk(rd, 24'hECA864, "R9 surplus bits ignored (5)");

    // R8: page write aborted keeps page
    do_write(5'd31, {24'd1, 8'h00}, 23, s);
    do_read(5'd20, 1'b0, rd, s);
    chk(rd, pat(20, 0), "R4 R8 aborted page write keeps page 0");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule